// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the shared register front end of a multi-timer event timer. It owns a 32-bit main counter that advances on a tick strobe, a global enable bit, a read-only capabilities word and an interrupt status word that the per-timer interrupt logic sets and software clears by writing ones. Each request is a single cycle carrying an address, a size in bytes and data. A read returns its data one cycle later.

The register map is 64 bits wide. A 4-byte request reaches either half of a register: address bit 2 selects the upper half. Requests of any other size, and requests that are not aligned to their own width, have no effect. Reads of them return zero, and so do reads of unmapped offsets. The block does not hold comparators. It sends the per-timer comparator blocks a stop pulse when counting halts, and a rearm pulse when counting resumes or the counter is overwritten while running. The comparators read the live counter from `count_o`.

Top module: `evt_timer_regs`

## Requirements
- R1: A request whose size is neither 4 nor 8 bytes changes no state, and a read of it returns zero one cycle later.
- R2: A 4-byte request with address bits 1:0 non-zero, or an 8-byte request with address bits 2:0 non-zero, changes no state, and a read of it returns zero.
- R3: A 4-byte request with address bit 2 set acts on bits 63:32 of the register at the address with bits 2:0 cleared. Write data bits 31:0 land in bits 63:32, and a read returns those bits in rd_data[31:0]. A 4-byte request with bit 2 clear acts on bits 31:0. Every 4-byte read returns zero in rd_data[63:32].
- R4: The capabilities word at offset 0x00 reads 0x038D7EA4_A5C30701 at default parameters. Its fields are: revision 1 in bits 7:0, timer count minus one (7) in bits 12:8, bit 13 clear for a 32-bit counter, vendor ID 0xA5C3 in bits 31:16, and the tick period in femtoseconds for a 2^24 Hz count rate in bits 63:32. Writes to this word have no effect.
- R5: The configuration register at 0x10 holds the global enable in bit 0. Bit 1 (legacy routing) and every other bit always read 0. Enable is 0 after reset.
- R6: The main counter resets to 0. It increments by one on each clock where tick_en is high and enable is 1, and holds otherwise.
- R7: A write that clears enable freezes the counter and drives stop_o to all ones for the one cycle after the write.
- R8: A write that sets enable resumes counting from the frozen value and drives rearm_o to all ones for the one cycle after the write.
- R9: A write to the counter at 0xF0 replaces the addressed half of the counter zero-extended to 64 bits, so an upper-half write leaves the counter unchanged. The write wins over a tick in the same cycle. If enable is 1, rearm_o is all ones for the following cycle.
- R10: The status register at 0x20 has bit n set by irq_set[n]. A write clears each bit whose write data bit is 1. A set wins over a clear in the same cycle.
- R11: Every read request drives rd_valid high for exactly the next cycle. Offsets outside 0x00, 0x10, 0x20 and 0xF0 (with bit 2 either way) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| irq_set | input | N_TIMERS | Status set requests from timers |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| count_o | output | 32 | Live main counter |
| cnt_enabled | output | 1 | Global enable |
| isr_o | output | N_TIMERS | Interrupt status bits |
| rearm_o | output | N_TIMERS | Per-timer rearm pulse |
| stop_o | output | N_TIMERS | Per-timer stop pulse |

## Verification
The directed phase uses full-width, lower-half and upper-half requests to the same registers. It separates correct half selection from a decoder that ignores address bit 2. Enable is toggled with the tick strobe held low and then pulsed a known number of times, which tells a frozen counter from one that keeps running. Counter writes are made both while enabled and while disabled, to show that rearm depends on the enable state. A random phase then mixes legal, odd-size, misaligned and unmapped requests with random ticks and status sets. This phase exposes ordering errors between a tick, a counter write and a same-cycle status set and clear.

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int N_TIMERS = 8,
  parameter int ADDR_W = 10,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter int FREQ_LOG2 = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic [63:0]         req_wdata,
  input  logic [N_TIMERS-1:0] irq_set,
  output logic                rd_valid,
  output logic [63:0]         rd_data,
  output logic [31:0]         count_o,
  output logic                cnt_enabled,
  output logic [N_TIMERS-1:0] isr_o,
  output logic [N_TIMERS-1:0] rearm_o,
  output logic [N_TIMERS-1:0] stop_o
);
  localparam logic [ADDR_W-1:0] OFS_CAP = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_CFG = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_ISR = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(12'h0F0);
  localparam logic [63:0] FS_PER_S = 64'd1000000000000000;
  localparam logic [63:0] TICK_FS64 = FS_PER_S >> FREQ_LOG2;
  localparam logic [4:0]  NT_M1 = 5'(N_TIMERS - 1);
  localparam logic [63:0] CAP_WORD = {TICK_FS64[31:0], VENDOR_ID, 3'b000, NT_M1, 8'h01};

  initial begin
    if (N_TIMERS < 3 || N_TIMERS > 32) $error("N_TIMERS out of range");
  end

  logic sz_ok, al_ok, acc_ok, hi_half, wr, rd;
  logic [ADDR_W-1:0] base;
  logic hit_cap, hit_cfg, hit_isr, hit_cnt;
  logic [63:0] wd, wmask, cnt_merge, rd_word, rd_sel;
  logic en_next;
  logic [N_TIMERS-1:0] isr_clr;

  assign sz_ok   = (req_size == 4'd4) || (req_size == 4'd8);
  assign al_ok   = (req_size == 4'd8) ? (req_addr[2:0] == 3'b000) : (req_addr[1:0] == 2'b00);
  assign acc_ok  = req_valid && sz_ok && al_ok;
  assign hi_half = (req_size == 4'd4) && req_addr[2];
  assign wr      = acc_ok && req_write;
  assign rd      = acc_ok && !req_write;
  assign base    = {req_addr[ADDR_W-1:3], 3'b000};

  assign hit_cap = (base == OFS_CAP);
  assign hit_cfg = (base == OFS_CFG);
  assign hit_isr = (base == OFS_ISR);
  assign hit_cnt = (base == OFS_CNT);

  assign wd    = hi_half ? {req_wdata[31:0], 32'h0} : req_wdata;
  assign wmask = (req_size == 4'd8) ? {64{1'b1}} :
                 hi_half ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};

  assign cnt_merge = ({32'h0, count_o} & ~wmask) | (wd & wmask);
  assign en_next   = (wr && hit_cfg && wmask[0]) ? wd[0] : cnt_enabled;
  assign isr_clr   = (wr && hit_isr) ? (wd[N_TIMERS-1:0] & wmask[N_TIMERS-1:0]) : '0;

  always_comb begin
    rd_word = 64'h0;
    if (hit_cap)      rd_word = CAP_WORD;
    else if (hit_cfg) rd_word = {63'h0, cnt_enabled};
    else if (hit_isr) rd_word = {{(64-N_TIMERS){1'b0}}, isr_o};
    else if (hit_cnt) rd_word = {32'h0, count_o};
  end

  assign rd_sel = hi_half ? {32'h0, rd_word[63:32]} :
                  (req_size == 4'd4) ? {32'h0, rd_word[31:0]} : rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o     <= 32'h0;
      cnt_enabled <= 1'b0;
      isr_o       <= '0;
      rearm_o     <= '0;
      stop_o      <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= 64'h0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= rd ? rd_sel : 64'h0;
      if (wr && hit_cnt)
        count_o <= cnt_merge[31:0];
      else if (cnt_enabled && tick_en)
        count_o <= count_o + 32'd1;
      cnt_enabled <= en_next;
      isr_o   <= (isr_o & ~isr_clr) | irq_set;
      stop_o  <= {N_TIMERS{cnt_enabled && !en_next}};
      rearm_o <= {N_TIMERS{(!cnt_enabled && en_next) || (wr && hit_cnt && cnt_enabled)}};
    end
  end
endmodule

module evt_timer_regs_chk #(
  parameter int N_TIMERS = 8,
  parameter int ADDR_W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [3:0]          req_size,
  input logic [N_TIMERS-1:0] irq_set,
  input logic                rd_valid,
  input logic [63:0]         rd_data,
  input logic [31:0]         count_o,
  input logic                cnt_enabled,
  input logic [N_TIMERS-1:0] isr_o,
  input logic [N_TIMERS-1:0] rearm_o,
  input logic [N_TIMERS-1:0] stop_o
);
  // R1
  bad_size_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 4'd4 && req_size != 4'd8) |=> (rd_data == 64'h0));
  // R2
  misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd8 && req_addr[2:0] != 3'b000) |=> (rd_data == 64'h0));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_enabled && tick_en && !req_valid) |=> (count_o == $past(count_o) + 32'd1));
  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_enabled && !req_valid) |=> $stable(count_o));
  // R7
  stop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_enabled) |-> (stop_o == {N_TIMERS{1'b1}}));
  // R7
  stop_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o != '0) |-> $fell(cnt_enabled));
  // R8
  rearm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_enabled) |-> (rearm_o == {N_TIMERS{1'b1}}));
  // R10
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((isr_o & $past(irq_set)) == $past(irq_set)));
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .irq_set(irq_set), .rd_valid(rd_valid), .rd_data(rd_data),
  .count_o(count_o), .cnt_enabled(cnt_enabled), .isr_o(isr_o),
  .rearm_o(rearm_o), .stop_o(stop_o));

// File: tb/tb_evt_timer_regs.sv
module tb_evt_timer_regs;
  logic clk = 0, rst_n = 0, tick_en = 0, req_valid = 0, req_write = 0;
  logic [9:0] req_addr = 0;
  logic [3:0] req_size = 0;
  logic [63:0] req_wdata = 0;
  logic [7:0] irq_set = 0;
  logic rd_valid, cnt_enabled;
  logic [63:0] rd_data;
  logic [31:0] count_o;
  logic [7:0] isr_o, rearm_o, stop_o;
  int total = 0, bad = 0;
  bit done = 0;
  localparam logic [63:0] CAP = 64'h038D7EA4_A5C30701;

  always #5 clk = ~clk;

  evt_timer_regs dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_set(irq_set), .rd_valid(rd_valid), .rd_data(rd_data), .count_o(count_o),
    .cnt_enabled(cnt_enabled), .isr_o(isr_o), .rearm_o(rearm_o), .stop_o(stop_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cnt;
  logic m_en, m_rdv;
  logic [7:0] m_isr, m_rearm, m_stop;
  logic [63:0] m_rd;
  always @(posedge clk) begin : model
    logic [63:0] v, wd, mk;
    logic [31:0] ncnt;
    logic [7:0] nisr;
    logic ok, hi;
    int a, sz;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_isr = 0; m_rearm = 0; m_stop = 0; m_rd = 0; m_rdv = 0;
    end else begin
      m_rdv = req_valid && !req_write; m_rd = 0; m_rearm = 0; m_stop = 0;
      ncnt = m_cnt + ((m_en && tick_en) ? 32'd1 : 32'd0);
      nisr = m_isr | irq_set;
      a = int'(req_addr); sz = int'(req_size);
      ok = (sz == 4 || sz == 8) && (a % (sz == 0 ? 1 : sz) == 0);
      hi = (sz == 4) && ((a / 4) % 2 == 1);
      a = a - (a % 8);
      if (req_valid && ok) begin
        if (!req_write) begin
          v = 0;
          if (a == 0) v = CAP;
          else if (a == 16) v = {63'h0, m_en};
          else if (a == 32) v = {56'h0, m_isr};
          else if (a == 240) v = {32'h0, m_cnt};
          if (hi) m_rd = v >> 32;
          else if (sz == 4) m_rd = v & 64'hFFFF_FFFF;
          else m_rd = v;
        end else begin
          wd = hi ? req_wdata << 32 : req_wdata;
          mk = (sz == 8) ? ~64'h0 : (hi ? 64'hFFFF_FFFF_0000_0000 : 64'hFFFF_FFFF);
          if (a == 16 && mk[0]) begin
            if (m_en && !wd[0]) m_stop = 8'hFF;
            if (!m_en && wd[0]) m_rearm = 8'hFF;
            m_en = wd[0];
          end else if (a == 32) begin
            nisr = (m_isr & ~(wd[7:0] & mk[7:0])) | irq_set;
          end else if (a == 240) begin
            v = ({32'h0, m_cnt} & ~mk) | (wd & mk);
            ncnt = v[31:0];
            if (m_en) m_rearm = 8'hFF;
          end
        end
      end
      m_cnt = ncnt; m_isr = nisr;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 count", {32'h0, count_o}, {32'h0, m_cnt});
    chk("R5 enable", {63'h0, cnt_enabled}, {63'h0, m_en});
    chk("R10 isr", {56'h0, isr_o}, {56'h0, m_isr});
    chk("R7 stop", {56'h0, stop_o}, {56'h0, m_stop});
    chk("R8 rearm", {56'h0, rearm_o}, {56'h0, m_rearm});
    chk("R11 rd_valid", {63'h0, rd_valid}, {63'h0, m_rdv});
    if (m_rdv) chk("R11 rd_data", rd_data, m_rd);
  end

  task automatic do_rd(input logic [9:0] a, input logic [3:0] s, output logic [63:0] d);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a; req_size = s;
    @(negedge clk); req_valid = 0; d = rd_data;
  endtask
  task automatic do_wr(input logic [9:0] a, input logic [3:0] s, input logic [63:0] w);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = w;
    @(negedge clk); req_valid = 0;
  endtask
  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick_en = 1; end
    @(negedge clk); tick_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset count", {32'h0, count_o}, 0);
    chk("R5 reset enable", {63'h0, cnt_enabled}, 0);
    do_rd(10'h000, 8, d); chk("R4 cap word", d, CAP);
    do_rd(10'h004, 4, d); chk("R3 cap upper half", d, 64'h038D7EA4);
    do_rd(10'h000, 4, d); chk("R3 cap lower half", d, 64'hA5C30701);
    do_wr(10'h000, 8, 0); do_rd(10'h000, 8, d); chk("R4 cap read only", d, CAP);
    do_wr(10'h010, 8, ~64'h0); do_rd(10'h010, 8, d); chk("R5 legacy and others zero", d, 1);
    do_wr(10'h014, 4, 0); do_rd(10'h010, 8, d); chk("R3 upper cfg write keeps enable", d, 1);
    do_wr(10'h0F0, 8, 100);
    chk("R9 rearm when enabled", {56'h0, rearm_o}, 64'hFF);
    ticks(5); do_rd(10'h0F0, 4, d); chk("R6 counted ticks", d, 105);
    do_wr(10'h0F4, 4, 64'hDEAD); do_rd(10'h0F0, 8, d); chk("R9 upper write no change", d, 105);
    do_wr(10'h0F0, 8, 64'h1_0000_0007); do_rd(10'h0F0, 8, d); chk("R9 zero extend", d, 7);
    do_wr(10'h010, 8, 0);
    chk("R7 stop pulse", {56'h0, stop_o}, 64'hFF);
    ticks(5); do_rd(10'h0F0, 8, d); chk("R7 frozen", d, 7);
    do_wr(10'h0F0, 4, 50);
    chk("R9 no rearm when disabled", {56'h0, rearm_o}, 0);
    do_rd(10'h0F0, 8, d); chk("R9 write while disabled", d, 50);
    do_wr(10'h010, 4, 1);
    chk("R8 rearm pulse", {56'h0, rearm_o}, 64'hFF);
    ticks(2); do_rd(10'h0F0, 8, d); chk("R8 resume", d, 52);
    do_wr(10'h010, 2, 0); do_rd(10'h010, 8, d); chk("R1 odd size write dropped", d, 1);
    do_rd(10'h010, 2, d); chk("R1 odd size read zero", d, 0);
    do_rd(10'h000, 1, d); chk("R1 byte read zero", d, 0);
    do_wr(10'h012, 4, 0); do_rd(10'h010, 8, d); chk("R2 misaligned write dropped", d, 1);
    do_rd(10'h014, 8, d); chk("R2 misaligned read zero", d, 0);
    do_rd(10'h011, 4, d); chk("R2 misaligned 4 read zero", d, 0);
    @(negedge clk); irq_set = 8'h05; @(negedge clk); irq_set = 0;
    do_rd(10'h020, 8, d); chk("R10 set", d, 5);
    do_wr(10'h020, 8, 4); do_rd(10'h020, 8, d); chk("R10 clear", d, 1);
    do_wr(10'h024, 4, 64'hFF); do_rd(10'h020, 8, d); chk("R10 upper clear no effect", d, 1);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 10'h020; req_size = 8;
    req_wdata = 1; irq_set = 8'h01;
    @(negedge clk); req_valid = 0; irq_set = 0;
    do_rd(10'h020, 8, d); chk("R10 set wins", d, 1);
    do_rd(10'h038, 8, d); chk("R11 unmapped zero", d, 0);
    do_rd(10'h104, 4, d); chk("R11 unmapped upper zero", d, 0);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      tick_en = ($urandom % 3) != 0;
      irq_set = (($urandom % 5) == 0) ? 8'($urandom) : 8'h0;
      req_valid = ($urandom % 2) == 1;
      req_write = ($urandom % 2) == 1;
      req_wdata = {$urandom, $urandom};
      case ($urandom % 6)
        0: req_size = 1; 1: req_size = 2; 2, 3: req_size = 4; default: req_size = 8;
      endcase
      case ($urandom % 10)
        0: req_addr = 10'h000; 1, 2: req_addr = 10'h010; 3: req_addr = 10'h014;
        4: req_addr = 10'h020; 5: req_addr = 10'h024; 6: req_addr = 10'h0F0;
        7: req_addr = 10'h0F4; default: req_addr = 10'($urandom);
      endcase
    end
    @(negedge clk); req_valid = 0; tick_en = 0; irq_set = 0;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule